// File: doc/BRIEF.md
# Flash Reset and Auto-Sleep Controller

This block governs the power state and the hardware-reset handling at the pins of a flash memory. It watches the address bus and puts the array read path to sleep once the address has stayed unchanged for a programmed number of clock cycles. While it sleeps, the data last fetched stays on the data output. The next address change wakes it, and data for the new address arrives with the usual one-cycle fetch latency. Chip enable, output enable and write enable play no part in this decision. Separately, it reports standby whenever the chip is deselected, the reset pin is high and no program or erase is running.

The active-low hardware reset pin passes through a width filter. A low pulse shorter than the minimum width is dropped. A pulse that reaches the minimum width sends a single-cycle abort to the command sequencer, so the sequencer stops its embedded operation and returns to read mode. From that point the data drivers are turned off and host reads and writes are blocked while the pin stays low. They stay blocked for a recovery interval after the pin rises. Ready/busy stays low for an internal-reset time. That time is longer when an embedded operation was running at the moment the reset was accepted.

Top module: `flash_pwr_reset_ctrl`

## Requirements
- R1: `sleep_o` rises once `addr_i` has been sampled unchanged on SLEEP_CYC consecutive clock edges after a change. Counting starts at the edge that first samples the new address, which sets the stable count to 0. `ce_n_i`, `oe_n_i` and `we_n_i` have no influence on the count.
- R2: When awake, `dout_o` takes `rdata_i` at every edge. While asleep with the address unchanged, `dout_o` holds its value even if `rdata_i` changes. The first edge that samples a new address clears `sleep_o` and loads `dout_o` with `rdata_i`.
- R3: With `ce_n_i`=1, `hw_rst_n_i`=1, `op_busy_i`=0 and the internal reset finished, `standby_o` is 1 and `dout_oe_o` is 0, whatever the value of `oe_n_i`.
- R4: While `op_busy_i`=1, `standby_o` stays 0 even when `ce_n_i`=1.
- R5: A low pulse on `hw_rst_n_i` that is sampled low on fewer than RST_MIN consecutive edges produces no abort and no blocking, and leaves `rdy_o` unchanged.
- R6: When `hw_rst_n_i` is sampled low on the RST_MIN-th consecutive edge, `abort_o` is 1 for exactly one cycle starting after that edge. From that cycle, `dout_oe_o` and `wr_req_o` are 0.
- R7: After a reset is accepted, `rdy_o` is 0 for RDY_BUSY_CYC cycles if `op_busy_i` was 1 at the accepting edge, and for RDY_IDLE_CYC cycles otherwise. It counts from the cycle in which `abort_o` is 1.
- R8: After the first edge that samples `hw_rst_n_i` high again, reads (`dout_oe_o`) and writes (`wr_req_o`) stay blocked for RECOV_CYC more cycles and are then allowed again.
- R9: `rdy_o` is 0 whenever `op_busy_i` is 1.
- R10: While `rst_n` is low at a clock edge, the block returns to: awake, no abort, `dout_o`=0, not blocked, internal reset finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| hw_rst_n_i | input | 1 | Active-low hardware reset pin, synchronous to clk |
| addr_i | input | AW | Address bus |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| op_busy_i | input | 1 | Program or erase in progress, from the command sequencer |
| rdata_i | input | DW | Data fetched from the array for the current address |
| dout_o | output | DW | Data presented to the pins, held while asleep |
| dout_oe_o | output | 1 | Drive enable for the data pins |
| wr_req_o | output | 1 | Write cycle accepted and passed to the sequencer |
| sleep_o | output | 1 | Automatic sleep active |
| standby_o | output | 1 | Standby state active |
| rdy_o | output | 1 | Ready (1) or busy (0) |
| abort_o | output | 1 | One-cycle abort pulse to the command sequencer |

## Verification
For the sleep path, the bench holds the address for every length from zero to two cycles past the threshold, while the strobes change each cycle. This separates a counter that fires one cycle early or late from a correct one, and it shows whether the strobes leak into the decision. On the reset path, pulse widths run from one cycle up to two cycles above the minimum. Each width is tried with no operation running, with an operation running, and with a write strobe held. This splits the filter boundary, the two ready delays and the recovery window apart, on both the read side and the write side. Changing array data during sleep, and then again after waking, shows the difference between holding the output and tracking the array.

// File: rtl/flrs_pkg.sv
// Shared types of the flash reset and auto-sleep controller.
package flrs_pkg;

    // Phase of the hardware-reset handling.
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,  // normal operation
        PH_HELD    = 2'd1,  // valid reset accepted, pin still low
        PH_RECOVER = 2'd2   // pin released, recovery interval running
    } rst_phase_t;

endpackage

// File: rtl/flrs_rst_filter.sv
// Hardware reset width filter and reset sequencing.
// Counts consecutive low samples of the reset pin. Once RST_MIN is reached,
// the reset is accepted: a single abort pulse is issued, host access is
// blocked until the pin rises plus RECOV cycles, and an internal-reset
// timer holds the block busy for RDY_BUSY or RDY_IDLE cycles. Which one
// applies depends on whether an operation was running at acceptance.
// Assumes hw_rst_n_i is already synchronous to clk. RST_MIN >= 1, RECOV >= 1.
module flrs_rst_filter
    import flrs_pkg::*;
#(
    parameter int RST_MIN  = 3,
    parameter int RDY_BUSY = 9,
    parameter int RDY_IDLE = 4,
    parameter int RECOV    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_rst_n_i,
    input  logic op_busy_i,
    output logic abort_o,
    output logic block_o,
    output logic int_busy_o
);
    localparam int RDY_MAX = (RDY_BUSY > RDY_IDLE) ? RDY_BUSY : RDY_IDLE;
    localparam int LW = $clog2(RST_MIN + 1);
    localparam int RW = $clog2(RDY_MAX + 1);
    localparam int CW = $clog2(RECOV + 1);

    logic [LW-1:0] low_cnt;
    logic [RW-1:0] int_cnt;
    logic [CW-1:0] rec_cnt;
    rst_phase_t    phase;
    logic          abort_q;
    logic          accept;

    // Accept on the edge that sees the RST_MIN-th consecutive low sample.
    assign accept = !hw_rst_n_i && (low_cnt == LW'(RST_MIN - 1));

    // Saturating count of consecutive low samples of the reset pin.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (hw_rst_n_i)
            low_cnt <= '0;
        else if (low_cnt != LW'(RST_MIN))
            low_cnt <= low_cnt + 1'b1;
    end

    // One-cycle abort pulse toward the command sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            abort_q <= 1'b0;
        else
            abort_q <= accept;
    end

    // Internal-reset timer; its length depends on the operation state at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            int_cnt <= '0;
        else if (accept)
            int_cnt <= op_busy_i ? RW'(RDY_BUSY) : RW'(RDY_IDLE);
        else if (int_cnt != '0)
            int_cnt <= int_cnt - 1'b1;
    end

    // Reset phase: held while the pin is low, then a recovery interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            rec_cnt <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (accept)
                        phase <= PH_HELD;
                end
                PH_HELD: begin
                    if (hw_rst_n_i) begin
                        phase   <= PH_RECOVER;
                        rec_cnt <= CW'(RECOV);
                    end
                end
                PH_RECOVER: begin
                    if (accept) begin
                        phase <= PH_HELD;
                    end else if (rec_cnt <= CW'(1)) begin
                        phase   <= PH_IDLE;
                        rec_cnt <= '0;
                    end else begin
                        rec_cnt <= rec_cnt - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign abort_o    = abort_q;
    assign block_o    = (phase != PH_IDLE);
    assign int_busy_o = (int_cnt != '0);

endmodule

// File: rtl/flrs_sleep_timer.sv
// Address-stability timer for automatic sleep.
// Registers the address each cycle and counts edges on which it is unchanged.
// Sleep is reported once SLEEP_CYC stable edges have been seen. Strobes are
// not inputs, so they cannot affect the decision. hold_o marks cycles in
// which the output data must not be refreshed.
module flrs_sleep_timer #(
    parameter int AW        = 4,
    parameter int SLEEP_CYC = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    output logic          sleep_o,
    output logic          hold_o
);
    localparam int SW = $clog2(SLEEP_CYC + 1);

    logic [AW-1:0] addr_q;
    logic [SW-1:0] st_cnt;
    logic          same;

    assign same = (addr_i == addr_q);

    // Track the previous address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else
            addr_q <= addr_i;
    end

    // Saturating count of stable-address edges; any change restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_cnt <= '0;
        else if (!same)
            st_cnt <= '0;
        else if (st_cnt != SW'(SLEEP_CYC))
            st_cnt <= st_cnt + 1'b1;
    end

    assign sleep_o = (st_cnt == SW'(SLEEP_CYC));
    // Freeze the data only while asleep and the address is still unchanged.
    assign hold_o  = sleep_o && same;

endmodule

// File: rtl/flrs_out_hold.sv
// Output data register with hold.
// Loads the array data every cycle unless hold_i is set, so the last value
// stays on the pins during sleep.
module flrs_out_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold_i,
    input  logic [DW-1:0] rdata_i,
    output logic [DW-1:0] dout_o
);
    logic [DW-1:0] dout_q;

    // Refresh or hold the presented data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout_q <= '0;
        else if (!hold_i)
            dout_q <= rdata_i;
    end

    assign dout_o = dout_q;

endmodule

// File: rtl/flash_pwr_reset_ctrl.sv
// Flash reset and auto-sleep controller (top).
// Combines the reset filter, the sleep timer and the output hold register.
// It derives drive enable, write acceptance, standby and ready/busy from
// the pin strobes. Assumes all inputs are synchronous to clk.
module flash_pwr_reset_ctrl #(
    parameter int AW        = 4,
    parameter int DW        = 8,
    parameter int SLEEP_CYC = 5,
    parameter int RST_MIN   = 3,
    parameter int RDY_BUSY  = 9,
    parameter int RDY_IDLE  = 4,
    parameter int RECOV     = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hw_rst_n_i,
    input  logic [AW-1:0] addr_i,
    input  logic          ce_n_i,
    input  logic          oe_n_i,
    input  logic          we_n_i,
    input  logic          op_busy_i,
    input  logic [DW-1:0] rdata_i,
    output logic [DW-1:0] dout_o,
    output logic          dout_oe_o,
    output logic          wr_req_o,
    output logic          sleep_o,
    output logic          standby_o,
    output logic          rdy_o,
    output logic          abort_o
);
    logic block;
    logic int_busy;
    logic hold;

    flrs_rst_filter #(
        .RST_MIN (RST_MIN),
        .RDY_BUSY(RDY_BUSY),
        .RDY_IDLE(RDY_IDLE),
        .RECOV   (RECOV)
    ) u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_rst_n_i(hw_rst_n_i),
        .op_busy_i (op_busy_i),
        .abort_o   (abort_o),
        .block_o   (block),
        .int_busy_o(int_busy)
    );

    flrs_sleep_timer #(
        .AW       (AW),
        .SLEEP_CYC(SLEEP_CYC)
    ) u_sleep (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr_i (addr_i),
        .sleep_o(sleep_o),
        .hold_o (hold)
    );

    flrs_out_hold #(
        .DW(DW)
    ) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (hold),
        .rdata_i(rdata_i),
        .dout_o (dout_o)
    );

    // Pin-level decode: read drive, write acceptance, standby and ready.
    always_comb begin
        dout_oe_o = !ce_n_i && !oe_n_i && we_n_i && !block;
        wr_req_o  = !ce_n_i && !we_n_i && oe_n_i && !block;
        standby_o = ce_n_i && hw_rst_n_i && !op_busy_i && !int_busy;
        rdy_o     = !op_busy_i && !int_busy;
    end

endmodule

// File: rtl/flash_pwr_reset_ctrl_chk.sv
// Assertion checker for the flash reset and auto-sleep controller.
// Observes only top-level ports; keeps its own count of low reset samples.
module flash_pwr_reset_ctrl_chk #(
    parameter int DW      = 8,
    parameter int RST_MIN = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hw_rst_n_i,
    input logic          op_busy_i,
    input logic [DW-1:0] dout_o,
    input logic          dout_oe_o,
    input logic          wr_req_o,
    input logic          sleep_o,
    input logic          standby_o,
    input logic          rdy_o,
    input logic          abort_o
);
    localparam int LW = $clog2(RST_MIN + 2);

    logic [LW-1:0] low_run;

    // Independent count of consecutive low samples of the reset pin.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_run <= '0;
        else if (hw_rst_n_i)
            low_run <= '0;
        else if (low_run != LW'(RST_MIN + 1))
            low_run <= low_run + 1'b1;
    end

    AST_ABORT_NEEDS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (low_run >= LW'(RST_MIN))); // R5

    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o); // R6

    AST_ABORT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (!dout_oe_o && !wr_req_o)); // R6

    AST_SLEEP_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && $past(sleep_o)) |-> $stable(dout_o)); // R2

    AST_STANDBY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        standby_o |-> !dout_oe_o); // R3

    AST_BUSY_NO_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        op_busy_i |-> !standby_o); // R4

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        op_busy_i |-> !rdy_o); // R9

endmodule

bind flash_pwr_reset_ctrl flash_pwr_reset_ctrl_chk #(
    .DW     (DW),
    .RST_MIN(RST_MIN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_rst_n_i(hw_rst_n_i),
    .op_busy_i (op_busy_i),
    .dout_o    (dout_o),
    .dout_oe_o (dout_oe_o),
    .wr_req_o  (wr_req_o),
    .sleep_o   (sleep_o),
    .standby_o (standby_o),
    .rdy_o     (rdy_o),
    .abort_o   (abort_o)
);

// File: tb/flash_pwr_reset_ctrl_test.sv
module flash_pwr_reset_ctrl_test;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int SC = 5;   // sleep threshold
    localparam int RM = 3;   // minimum reset width
    localparam int RB = 9;   // ready delay, operation running
    localparam int RI = 4;   // ready delay, idle
    localparam int RC = 3;   // recovery interval

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic          rst_n, hw, ce_n, oe_n, we_n, opb;
    logic [AW-1:0] addr;
    logic [DW-1:0] salt;
    logic [DW-1:0] dout;
    logic          dout_oe, wr_req, sleep, standby, rdy, abort_p;

    int total = 0;
    int bad   = 0;

    function automatic logic [DW-1:0] fdat(input logic [AW-1:0] a, input logic [DW-1:0] s);
        return {a, ~a} ^ s;
    endfunction

    wire [DW-1:0] rdata = fdat(addr, salt);

    flash_pwr_reset_ctrl #(
        .AW(AW), .DW(DW), .SLEEP_CYC(SC), .RST_MIN(RM),
        .RDY_BUSY(RB), .RDY_IDLE(RI), .RECOV(RC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .hw_rst_n_i(hw), .addr_i(addr),
        .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n), .op_busy_i(opb),
        .rdata_i(rdata), .dout_o(dout), .dout_oe_o(dout_oe), .wr_req_o(wr_req),
        .sleep_o(sleep), .standby_o(standby), .rdy_o(rdy), .abort_o(abort_p)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [AW-1:0] a_sl;
        logic [DW-1:0] held;
        rst_n = 1'b0; hw = 1'b1; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        opb = 1'b0; addr = '0; salt = '0;
        repeat (3) @(negedge clk);
        // R10: state during system reset
        chk(sleep == 1'b0,   "R10 sleep",   sleep,   0);
        chk(abort_p == 1'b0, "R10 abort",   abort_p, 0);
        chk(rdy == 1'b1,     "R10 ready",   rdy,     1);
        chk(dout == '0,      "R10 dout",    dout,    0);
        chk(standby == 1'b1, "R10 standby", standby, 1);
        rst_n = 1'b1;
        ce_n = 1'b0; oe_n = 1'b0;

        // R1: stability sweep with strobes changing every cycle
        for (int g = 0; g <= SC + 1; g++) begin
            addr = AW'(g + 1);
            for (int i = 0; i <= g; i++) begin
                @(negedge clk);
                chk(sleep == (i >= SC), "R1 sleep entry", sleep, int'(i >= SC));
                if (i == 0)
                    chk(dout == fdat(addr, salt), "R2 fetch", dout, fdat(addr, salt));
                ce_n = i[0]; oe_n = i[1]; we_n = ~i[2];
            end
        end
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;

        // R2: hold while asleep, then wake on address change
        a_sl = addr;
        held = dout;
        salt = 8'h5A;
        repeat (2) begin
            @(negedge clk);
            chk(sleep == 1'b1, "R2 still asleep", sleep, 1);
            chk(dout == held,  "R2 hold", dout, held);
        end
        addr = a_sl + 4'd3;
        @(negedge clk);
        chk(sleep == 1'b0, "R2 wake", sleep, 0);
        chk(dout == fdat(addr, salt), "R2 wake data", dout, fdat(addr, salt));
        salt = 8'h33;
        @(negedge clk);
        chk(dout == fdat(addr, salt), "R2 awake tracks", dout, fdat(addr, salt));

        // R3 / R4 / R9: standby and busy
        ce_n = 1'b1; oe_n = 1'b0;
        #1;
        chk(standby == 1'b1, "R3 standby", standby, 1);
        chk(dout_oe == 1'b0, "R3 tristate", dout_oe, 0);
        opb = 1'b1;
        #1;
        chk(standby == 1'b0, "R4 busy deselect", standby, 0);
        chk(rdy == 1'b0,     "R9 busy", rdy, 0);
        opb = 1'b0; ce_n = 1'b0;
        #1;
        chk(dout_oe == 1'b1, "R3 selected drive", dout_oe, 1);

        // R5..R8: reset width sweep; m=0 idle, m=1 operation running, m=2 write strobe
        for (int m = 0; m < 3; m++) begin
            for (int L = 1; L <= RM + 2; L++) begin
                bit valid;
                bit opb_now;
                int n;
                @(negedge clk);
                valid   = (L >= RM);
                opb_now = (m == 1);
                n       = (m == 1) ? RB : RI;
                opb  = opb_now;
                ce_n = 1'b0;
                oe_n = (m == 2);
                we_n = (m != 2);
                hw   = 1'b0;
                for (int t = 1; t <= L + n + RC + 2; t++) begin
                    bit e_ab, e_blk, e_rdy;
                    @(negedge clk);
                    e_ab  = valid && (t == RM);
                    e_blk = valid && (t >= RM) && (t <= L + RC);
                    e_rdy = !opb_now && !(valid && (t >= RM) && (t <= RM + n - 1));
                    if (!valid) begin
                        chk(abort_p == 1'b0, "R5 no abort", abort_p, 0);
                        if (m == 2) chk(wr_req == 1'b1, "R5 write kept", wr_req, 1);
                        else        chk(dout_oe == 1'b1, "R5 read kept", dout_oe, 1);
                        chk(rdy == e_rdy, "R5 ready kept", rdy, e_rdy);
                    end else begin
                        chk(abort_p == e_ab, "R6 abort pulse", abort_p, e_ab);
                        if (m == 2) chk(wr_req == !e_blk, "R8 write block", wr_req, !e_blk);
                        else        chk(dout_oe == !e_blk, "R8 read block", dout_oe, !e_blk);
                        chk(rdy == e_rdy, "R7 ready delay", rdy, e_rdy);
                    end
                    if (t == L) hw = 1'b1;
                    if (valid && t == RM) begin
                        opb_now = 1'b0;
                        opb = 1'b0;
                    end
                end
                opb = 1'b0;
            end
        end

        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule